// File: doc/BRIEF.md
# Register-Programmed I2C Bus Master

This block is a single-master I2C controller that software drives through a small register file. Software loads a target address with a direction flag, a data byte and a bit-rate setting. It then writes one command word. That word may ask for a start condition, a one-byte transfer and a stop condition in any combination. The controller always performs the requested phases in that fixed order on an open-drain clock line and an open-drain data line. Each line has an input and an active-high pull-down enable. When a byte moves, the controller raises a maskable interrupt. A status word reports progress, faults and whether the controller owns the bus.

The register index (`reg_addr`) selects one of the following: 0 target address, 1 command (write) or status (read), 2 data byte, 3 bit-period setting, 4 interrupt mask, 5 raw interrupt, 6 masked interrupt, 7 interrupt clear (write only, reads 0), 8 configuration. Any other index reads 0. Writes take effect on the clock edge. Reads are combinational. Status bits: 0x01 busy, 0x02 error, 0x04 address not acknowledged, 0x08 data not acknowledged, 0x10 arbitration lost, 0x20 idle, 0x40 bus owned.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, status reads 0x20, the period setting reads 1, every other register reads 0, both pull-downs are off and `irq` is low.
- R2: A command write is ignored while configuration bit 4 (enable) is clear or while busy. There is no bus activity and status is unchanged.
- R3: The configuration register keeps only bits 0, 4 and 5 (mask 0x31). The target-address register keeps all 8 bits: bits 7:1 are the 7-bit address and bit 0 selects read (1) or write (0).
- R4: Command bit 1 is START, bit 0 is RUN and bit 2 is STOP. When set, they occur on the bus in this order: start condition, address byte, data byte, stop condition.
- R5: In write direction, RUN shifts the data register out MSB first and then sets raw interrupt bit 0.
- R6: One SCL period lasts 20 × (1 + period setting) clocks. Within a byte, SDA changes only while SCL is low.
- R7: `irq` is raw bit 0 AND mask bit 0. Writing 1 to bit 0 of the clear register clears raw bit 0.
- R8: START without STOP leaves the bus owned (status 0x40). Later RUN-only or STOP-only commands continue the transfer, and STOP clears bus-owned.
- R9: A command issued while the bus is not owned sets error (0x02) and moves no byte. A command that finds the bus owned clears error.
- R10: In read direction, RUN loads the received byte into the data register. The master acknowledges the byte unless STOP is in the same command, in which case it does not acknowledge.
- R11: A NACK of the address byte sets 0x04 and error, skips RUN and still performs a requested STOP. A NACK of a data byte sets 0x08 and error.
- R12: START is tried only when bus-owned is clear. If SCL or SDA is low at that moment, arbitration-lost (0x10) is set and the command then fails with error. A successful START clears arbitration-lost.
- R13: From an accepted command until its last requested phase ends, busy (0x01) is set and idle (0x20) is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| scl_i | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench targets commands split across several writes. If the bus were dropped after a START-only command, a later RUN would wrongly report error instead of shifting its byte out. It also covers a RUN with no bus ownership, where a design that skipped the ownership check would clock a stray byte onto the bus. Address and data NACKs are checked separately: mixing up the two flags, or running the data phase after a refused address, shows up as a wrong status word or an unexpected byte on the bus. A START against a held-low clock must leave the bus untouched and report arbitration loss. The measured SCL period catches an off-by-one in the divider.

// File: rtl/i2c_reg_master.sv
module i2c_reg_master #(
  parameter int PW   = 8,
  parameter int QMUL = 5,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  input  logic          scl_i,
  output logic          scl_oe,
  input  logic          sda_i,
  output logic          sda_oe
);
  localparam int QW = PW + $clog2(QMUL) + 1;
  localparam logic [AW-1:0] A_SLV  = AW'(0);
  localparam logic [AW-1:0] A_CMD  = AW'(1);
  localparam logic [AW-1:0] A_DATA = AW'(2);
  localparam logic [AW-1:0] A_PER  = AW'(3);
  localparam logic [AW-1:0] A_MASK = AW'(4);
  localparam logic [AW-1:0] A_RAW  = AW'(5);
  localparam logic [AW-1:0] A_MIS  = AW'(6);
  localparam logic [AW-1:0] A_ICLR = AW'(7);
  localparam logic [AW-1:0] A_CFG  = AW'(8);

  typedef enum logic [3:0] {
    S_IDLE, S_FREE, S_SDA, S_SCL, S_BIT, S_OWN, S_P0, S_P1, S_P2, S_P3
  } st_t;

  st_t st;
  logic [7:0] slv, data, cfg, shreg;
  logic [PW-1:0] period;
  logic mask, raw;
  logic busy, err, adrack, datack, arblst, busbsy;
  logic cmd_run, cmd_stop, dir_rd, is_addr, nack_pend, ackbit;
  logic [1:0] qph;
  logic [3:0] bidx;
  logic [QW-1:0] qcnt, qload;
  logic stretch, tick_ok, qdone, cmd_go;
  logic [7:0] status;

  assign qload   = QW'(QMUL) * (QW'(period) + QW'(1)) - QW'(1);
  assign stretch = (st == S_BIT && qph == 2'd2) || st == S_P2;
  assign tick_ok = !(stretch && !scl_i);
  assign qdone   = (qcnt == '0) && tick_ok;
  assign cmd_go  = reg_we && reg_addr == A_CMD && cfg[4] && !busy;
  assign status  = {1'b0, busbsy, !busy, arblst, datack, adrack, err, busy};
  assign irq     = raw & mask;

  always_comb begin
    case (reg_addr)
      A_SLV:   reg_rdata = slv;
      A_CMD:   reg_rdata = status;
      A_DATA:  reg_rdata = data;
      A_PER:   reg_rdata = 8'(period);
      A_MASK:  reg_rdata = {7'b0, mask};
      A_RAW:   reg_rdata = {7'b0, raw};
      A_MIS:   reg_rdata = {7'b0, raw & mask};
      A_CFG:   reg_rdata = cfg;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; slv <= '0; data <= '0; cfg <= '0; shreg <= '0;
      period <= PW'(1); mask <= 1'b0; raw <= 1'b0;
      busy <= 1'b0; err <= 1'b0; adrack <= 1'b0; datack <= 1'b0;
      arblst <= 1'b0; busbsy <= 1'b0;
      cmd_run <= 1'b0; cmd_stop <= 1'b0; dir_rd <= 1'b0; is_addr <= 1'b0;
      nack_pend <= 1'b0; ackbit <= 1'b0;
      qph <= '0; bidx <= '0; qcnt <= '0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_SLV:  slv <= reg_wdata;
          A_DATA: data <= reg_wdata;
          A_PER:  period <= PW'(reg_wdata);
          A_MASK: mask <= reg_wdata[0];
          A_ICLR: if (reg_wdata[0]) raw <= 1'b0;
          A_CFG:  cfg <= reg_wdata & 8'h31;
          default: ;
        endcase
      end
      if (qcnt != '0 && tick_ok) qcnt <= qcnt - QW'(1);

      case (st)
        S_IDLE: if (cmd_go) begin
          busy <= 1'b1;
          cmd_run <= reg_wdata[0];
          cmd_stop <= reg_wdata[2];
          dir_rd <= slv[0];
          adrack <= 1'b0; datack <= 1'b0; nack_pend <= 1'b0;
          if (reg_wdata[1] && !busbsy) begin
            st <= S_FREE; qcnt <= qload;
          end else st <= S_OWN;
        end
        S_FREE: if (qdone) begin
          if (scl_i && sda_i) begin
            busbsy <= 1'b1; arblst <= 1'b0; sda_oe <= 1'b1;
            st <= S_SDA; qcnt <= qload;
          end else begin
            arblst <= 1'b1; st <= S_OWN;
          end
        end
        S_SDA: if (qdone) begin
          scl_oe <= 1'b1; st <= S_SCL; qcnt <= qload;
        end
        S_SCL: if (qdone) begin
          st <= S_BIT; qph <= 2'd0; bidx <= '0; shreg <= slv; is_addr <= 1'b1;
          qcnt <= qload;
        end
        S_BIT: if (qdone) begin
          qcnt <= qload;
          case (qph)
            2'd0: begin
              qph <= 2'd1;
              if (bidx < 4'd8) sda_oe <= (is_addr || !dir_rd) ? !shreg[7] : 1'b0;
              else             sda_oe <= (is_addr || !dir_rd) ? 1'b0 : !cmd_stop;
            end
            2'd1: begin
              scl_oe <= 1'b0; qph <= 2'd2;
            end
            2'd2: begin
              if (bidx < 4'd8) shreg <= {shreg[6:0], sda_i};
              else             ackbit <= sda_i;
              qph <= 2'd3;
            end
            default: begin
              scl_oe <= 1'b1; qph <= 2'd0;
              if (bidx != 4'd8) bidx <= bidx + 4'd1;
              else if (is_addr) begin
                nack_pend <= ackbit; st <= S_OWN;
              end else begin
                raw <= 1'b1;
                if (dir_rd) data <= shreg;
                else if (ackbit) begin datack <= 1'b1; err <= 1'b1; end
                if (cmd_stop) st <= S_P0;
                else begin busy <= 1'b0; st <= S_IDLE; end
              end
            end
          endcase
        end
        S_OWN: begin
          if (!busbsy) begin
            err <= 1'b1; busy <= 1'b0; st <= S_IDLE;
          end else if (nack_pend) begin
            err <= 1'b1; adrack <= 1'b1;
            if (cmd_stop) begin st <= S_P0; qcnt <= qload; end
            else begin busy <= 1'b0; st <= S_IDLE; end
          end else begin
            err <= 1'b0;
            if (cmd_run) begin
              st <= S_BIT; qph <= 2'd0; bidx <= '0; shreg <= data; is_addr <= 1'b0;
              qcnt <= qload;
            end else if (cmd_stop) begin
              st <= S_P0; qcnt <= qload;
            end else begin
              busy <= 1'b0; st <= S_IDLE;
            end
          end
        end
        S_P0: if (qdone) begin sda_oe <= 1'b1; st <= S_P1; qcnt <= qload; end
        S_P1: if (qdone) begin scl_oe <= 1'b0; st <= S_P2; qcnt <= qload; end
        S_P2: if (qdone) begin sda_oe <= 1'b0; st <= S_P3; qcnt <= qload; end
        S_P3: if (qdone) begin busbsy <= 1'b0; busy <= 1'b0; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_start_needs_free_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busbsy) |-> $past(scl_i && sda_i));

  p_disabled_cmd_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CMD && !cfg[4] && !busy) |=> !busy);

  p_sda_steady_scl_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && $past(st) == S_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  p_released_when_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !busbsy) |-> (!scl_oe && !sda_oe));

  p_raw_after_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw) |-> $past(st == S_BIT));

endmodule

// File: tb/i2c_reg_master_tb_top.sv
`timescale 1ns/1ps
module i2c_reg_master_tb_top;
  localparam int START = 256;
  localparam int STOP  = 512;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic scl_force = 1'b0;
  logic s_low = 1'b0;
  wire scl_line = !(scl_oe | scl_force);
  wire sda_line = !(sda_oe | s_low);

  int n_checks = 0;
  int n_errors = 0;
  int obs_n = 0;
  int exp_q[$];

  i2c_reg_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe));

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_item(input int item);
    exp_q.push_back(item);
  endtask

  task automatic observe(input int item);
    obs_n++;
    if (exp_q.size() == 0) chk("R4 unexpected bus event", item, -1);
    else chk("R4 bus event order", item, exp_q.pop_front());
  endtask

  // bus-side target model and monitor
  bit p_scl = 1, p_sda = 1, in_frame = 0, is_adr = 0, rd = 0, ok = 0, tx_on = 0, mack = 0;
  int bcnt = 0;
  logic [7:0] sr = '0, txb = 8'hC5;
  time last_rise = 0, per_ns = 0;

  always @(scl_line or sda_line) begin
    if (scl_line && p_scl) begin
      if (!sda_line && p_sda) begin
        in_frame = 1; bcnt = 0; is_adr = 1; tx_on = 0; s_low = 0; observe(START);
      end else if (sda_line && !p_sda) begin
        in_frame = 0; tx_on = 0; s_low = 0; observe(STOP);
      end
    end
    if (scl_line && !p_scl && in_frame) begin
      if (bcnt < 8) begin
        sr = {sr[6:0], sda_line};
        if (bcnt > 0) per_ns = $time - last_rise;
      end else if (!is_adr && rd && tx_on) begin
        mack = !sda_line;
        if (!mack) tx_on = 0;
      end
      last_rise = $time;
      bcnt++;
    end
    if (!scl_line && p_scl && in_frame) begin
      if (bcnt == 8) begin
        observe(int'(sr));
        if (is_adr) begin
          ok = (sr[7:1] == SLV); rd = sr[0]; s_low = ok;
        end else if (rd) s_low = 0;
        else s_low = (sr != 8'hEE);
      end else if (bcnt == 9) begin
        bcnt = 0; s_low = 0;
        if (is_adr && rd && ok) tx_on = 1;
        is_adr = 0;
        if (tx_on) s_low = !txb[7];
      end else if (tx_on) s_low = !txb[7-bcnt];
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    for (int i = 0; i < 50000; i++) begin
      rd_reg(4'd1, s);
      if (!s[0]) break;
    end
  endtask

  task automatic run_cmd(input logic [7:0] c);
    wr(4'd1, c); wait_done();
  endtask

  initial begin
    #1_500_000;
    chk("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int o;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_reg(4'd1, v); chk("R1 status", v, 8'h20);
    rd_reg(4'd3, v); chk("R1 period", v, 1);
    rd_reg(4'd0, v); chk("R1 address", v, 0);
    rd_reg(4'd8, v); chk("R1 config", v, 0);
    chk("R1 lines/irq", {irq, scl_oe, sda_oe}, 0);
    // R2 disabled
    o = obs_n;
    wr(4'd1, 8'h07);
    repeat (60) @(negedge clk);
    rd_reg(4'd1, v); chk("R2 disabled status", v, 8'h20);
    chk("R2 disabled no bus activity", obs_n, o);
    // R3 config mask
    wr(4'd8, 8'hFF); rd_reg(4'd8, v); chk("R3 config mask", v, 8'h31);
    wr(4'd8, 8'h10);
    wr(4'd0, 8'hA7); rd_reg(4'd0, v); chk("R3 address 8 bits", v, 8'hA7);
    // R4 R5 R6 R13 full write at period 3
    wr(4'd3, 8'd3); wr(4'd0, 8'h54); wr(4'd2, 8'h9C);
    expect_item(START); expect_item(8'h54); expect_item(8'h9C); expect_item(STOP);
    wr(4'd1, 8'h07);
    rd_reg(4'd1, v); chk("R13 busy before start", v, 8'h01);
    repeat (30) @(negedge clk);
    rd_reg(4'd1, v); chk("R13 busy and owned", v, 8'h41);
    wait_done();
    rd_reg(4'd1, v); chk("R4 status after", v, 8'h20);
    chk("R4 all events seen", exp_q.size(), 0);
    chk("R6 SCL period ns", int'(per_ns), 800);
    rd_reg(4'd5, v); chk("R5 raw set", v, 1);
    // R7 interrupt
    chk("R7 irq masked", irq, 0);
    wr(4'd4, 8'h01); #1; chk("R7 irq unmasked", irq, 1);
    rd_reg(4'd6, v); chk("R7 masked status", v, 1);
    wr(4'd7, 8'h01); #1; chk("R7 irq cleared", irq, 0);
    rd_reg(4'd5, v); chk("R7 raw cleared", v, 0);
    // R8 split command, R2 busy ignore
    wr(4'd3, 8'd0); wr(4'd2, 8'h3C);
    expect_item(START); expect_item(8'h54); expect_item(8'h3C);
    run_cmd(8'h03);
    rd_reg(4'd1, v); chk("R8 owned after start+run", v, 8'h60);
    wr(4'd2, 8'h81); expect_item(8'h81);
    wr(4'd1, 8'h01);
    wr(4'd1, 8'h04);
    wait_done();
    rd_reg(4'd1, v); chk("R2 stop while busy ignored", v, 8'h60);
    expect_item(STOP);
    run_cmd(8'h04);
    rd_reg(4'd1, v); chk("R8 stop releases", v, 8'h20);
    chk("R8 events seen", exp_q.size(), 0);
    // R9 not owned
    o = obs_n;
    run_cmd(8'h01);
    rd_reg(4'd1, v); chk("R9 error without bus", v, 8'h22);
    chk("R9 no byte moved", obs_n, o);
    // R10 read with stop
    wr(4'd0, 8'h55);
    expect_item(START); expect_item(8'h55); expect_item(8'hC5); expect_item(STOP);
    mack = 1;
    run_cmd(8'h07);
    rd_reg(4'd2, v); chk("R10 received byte", v, 8'hC5);
    chk("R10 last byte not acknowledged", mack, 0);
    rd_reg(4'd1, v); chk("R9 error cleared when owned", v, 8'h20);
    // R11 address nack
    wr(4'd7, 8'h01); wr(4'd0, 8'h40);
    expect_item(START); expect_item(8'h40); expect_item(STOP);
    run_cmd(8'h07);
    rd_reg(4'd1, v); chk("R11 address nack status", v, 8'h26);
    rd_reg(4'd5, v); chk("R11 run skipped", v, 0);
    // R11 data nack
    wr(4'd0, 8'h54); wr(4'd2, 8'hEE);
    expect_item(START); expect_item(8'h54); expect_item(8'hEE); expect_item(STOP);
    run_cmd(8'h07);
    rd_reg(4'd1, v); chk("R11 data nack status", v, 8'h2A);
    // R12 bus not free
    o = obs_n;
    scl_force = 1;
    run_cmd(8'h07);
    rd_reg(4'd1, v); chk("R12 arbitration lost", v, 8'h32);
    chk("R12 no bus events", obs_n, o);
    scl_force = 0;
    wr(4'd2, 8'h5A);
    expect_item(START); expect_item(8'h54); expect_item(8'h5A); expect_item(STOP);
    run_cmd(8'h07);
    rd_reg(4'd1, v); chk("R12 cleared by good start", v, 8'h20);
    chk("R4 final queue empty", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule